// File: doc/BRIEF.md
# Command Response Buffer Controller

This block is the register front end of a security coprocessor that takes commands through a shared buffer. A host writes 1 to 4 bytes at a time over a simple write bus. Writes at or above offset 0x80 fill an on-chip command buffer. Writes below that offset go to a small set of control registers. These registers track which locality owns the interface, whether the engine should be idle or ready, and whether a command is in flight.

When the owning locality writes the start code, the block marks the command as in flight. It then gives the engine behind it a one-cycle request together with the command length. The length comes from the buffer header and is capped at the buffer size. The engine reports the end of the command with a completion strobe and an error flag. While a command is in flight, the host may raise a one-cycle cancel toward the engine.

The capability word and the buffer descriptor words are fixed values. They are available from reset. All registers and buffer words can be read through a combinational read port addressed by page offset.

Top module: `cmd_buf_ctrl`

## Requirements
- R1: Reset sets the registers to these values:
  - locality-state word (0x00) reads 0x81: bit 0 = established, bit 7 = register-valid.
  - control-status word (0x44) reads 0x2: bit 1 = idle, bit 0 = fatal.
  - locality-status (0x0C) reads 0.
  - start (0x4C) reads 0.
  - every buffer byte reads 0.
  - the capability word at 0x30 reads 0x00025A11.
- R2: The command size (0x58) and response size (0x64) words read the buffer size. The command and response low address words (0x5C, 0x68) and high address words (0x60, 0x6C) hold the block base address plus 0x80.
- R3: Buffer writes are little-endian:
  - a write whose page offset is at or above 0x80 stores byte i of the write data at offset+i, for i below the access size.
  - bytes that fall past the buffer end are dropped.
  - an access size of 0 or above 4 makes the whole write have no effect.
- R4: Control request (0x40): a value of 1 clears the idle bit, a value of 2 sets it, and any other value has no effect.
- R5: Locality control (0x08):
  - value 1 sets granted (0x0C bit 0), clears seized (0x0C bit 1) and sets assigned (0x00 bit 1).
  - value 2 clears assigned and granted.
  - value 8, and any other value, has no effect.
- R6: A start write (value 1 to 0x4C) is accepted only if all of these hold:
  - the start bit is clear.
  - the locality is assigned.
  - the locality field of the address (address bits 12 and up) equals the active locality, which is 0.

  If it is accepted, the start bit is set and req_valid is high for exactly one cycle after the write edge.
- R7: req_len is the smaller of two values: the big-endian 32-bit value in buffer bytes 2 to 5, and the buffer size.
- R8: Writing value 1 to cancel (0x48) pulses cancel_pulse for one cycle only while the start bit is set. Any other cancel write has no effect. The cancel word reads 0.
- R9: A completion strobe clears the start bit. If its error flag is set, it also sets the fatal bit (0x44 bit 0), which stays set until reset.
- R10: A register write compares the write data masked to the access size, taking 1 to 4 low bytes, against the command codes.
- R11: Reads ignore the two low offset bits. Offsets that map to no register and lie outside the buffer read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Write address: page offset in bits 11:0, locality above |
| bus_wdata | input | 32 | Write data, little-endian lanes |
| bus_size | input | 3 | Access size in bytes (1 to 4 valid) |
| rd_off | input | 12 | Read page offset |
| rd_data | output | 32 | Combinational read data |
| req_valid | output | 1 | One-cycle command request to the engine |
| req_len | output | clog2(BUF_BYTES+1) | Command length for the request |
| cancel_pulse | output | 1 | One-cycle cancel request to the engine |
| done_valid | input | 1 | Command completion strobe |
| done_err | input | 1 | Completion carries an error |

## Verification
Several properties are checked on every cycle:
- a request is issued only while the start bit is set, and it never lasts two cycles.
- a cancel follows only an in-flight cycle.
- granted and assigned always move together.
- fatal is sticky.
- a completion during a command clears start.
- the length never exceeds the buffer size.

Other behaviour needs the bench's scenarios to show it: the exact reset and descriptor values, little-endian lane placement and dropping at the buffer end, rejection of start from a foreign or unassigned locality, masking of codes by access size, and the length cap taken from a real header.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
    localparam logic [11:0] OFF_LOC_STATE = 12'h000;
    localparam logic [11:0] OFF_LOC_CTRL  = 12'h008;
    localparam logic [11:0] OFF_LOC_STS   = 12'h00C;
    localparam logic [11:0] OFF_IF_ID     = 12'h030;
    localparam logic [11:0] OFF_IF_ID2    = 12'h034;
    localparam logic [11:0] OFF_CTRL_REQ  = 12'h040;
    localparam logic [11:0] OFF_CTRL_STS  = 12'h044;
    localparam logic [11:0] OFF_CANCEL    = 12'h048;
    localparam logic [11:0] OFF_START     = 12'h04C;
    localparam logic [11:0] OFF_CMD_SIZE  = 12'h058;
    localparam logic [11:0] OFF_CMD_LO    = 12'h05C;
    localparam logic [11:0] OFF_CMD_HI    = 12'h060;
    localparam logic [11:0] OFF_RSP_SIZE  = 12'h064;
    localparam logic [11:0] OFF_RSP_LO    = 12'h068;
    localparam logic [11:0] OFF_RSP_HI    = 12'h06C;
    localparam logic [11:0] OFF_BUF       = 12'h080;

    localparam logic [31:0] CODE_READY     = 32'd1;
    localparam logic [31:0] CODE_IDLE      = 32'd2;
    localparam logic [31:0] CODE_CANCEL    = 32'd1;
    localparam logic [31:0] CODE_START     = 32'd1;
    localparam logic [31:0] CODE_LOC_REQ   = 32'd1;
    localparam logic [31:0] CODE_LOC_FREE  = 32'd2;

    typedef struct packed {
        logic       established;
        logic       assigned;
        logic [2:0] act_loc;
        logic       reg_valid;
        logic       granted;
        logic       seized;
        logic       idle;
        logic       fatal;
        logic       start;
    } ctrl_state_t;

    localparam ctrl_state_t ST_RST = '{
        established: 1'b1, assigned: 1'b0, act_loc: 3'd0, reg_valid: 1'b1,
        granted: 1'b0, seized: 1'b0, idle: 1'b1, fatal: 1'b0, start: 1'b0};

    typedef struct packed {
        logic loc_ctrl;
        logic ctrl_req;
        logic cancel;
        logic start;
    } reg_hit_t;

    function automatic logic [31:0] size_mask(input logic [2:0] sz);
        case (sz)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            3'd3:    return 32'h00FF_FFFF;
            3'd4:    return 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    // Capability word: type=CRB active, version=CRB, idle bypass=fast,
    // transfer size=64 bytes, CRB supported, selector=CRB, locality 0 only.
    function automatic logic [31:0] cap_word();
        logic [31:0] w;
        w          = '0;
        w[3:0]     = 4'd1;
        w[7:4]     = 4'd1;
        w[9]       = 1'b1;
        w[12:11]   = 2'd3;
        w[14]      = 1'b1;
        w[18:17]   = 2'd1;
        return w;
    endfunction
endpackage

// File: rtl/cbc_wr_decode.sv
module cbc_wr_decode
    import cbc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BUF_BYTES = 128,
    localparam int LOC_W    = ADDR_W - 12
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [2:0]        size,
    output logic [LOC_W-1:0]  loc,
    output logic [31:0]       val,
    output reg_hit_t          hit,
    output logic              buf_wr,
    output logic [11:0]       buf_idx
);
    logic [11:0] off;
    logic        size_ok;
    logic        in_buf;

    always_comb begin
        off     = addr[11:0];
        loc     = addr[ADDR_W-1:12];
        size_ok = (size >= 3'd1) && (size <= 3'd4);
        val     = wdata & size_mask(size);
        in_buf  = (int'(off) >= int'(OFF_BUF)) && (int'(off) < int'(OFF_BUF) + BUF_BYTES);
        buf_wr  = wr && size_ok && in_buf;
        buf_idx = off - OFF_BUF;
        hit.loc_ctrl = wr && size_ok && (off == OFF_LOC_CTRL);
        hit.ctrl_req = wr && size_ok && (off == OFF_CTRL_REQ);
        hit.cancel   = wr && size_ok && (off == OFF_CANCEL);
        hit.start    = wr && size_ok && (off == OFF_START);
    end
endmodule

// File: rtl/cbc_data_buf.sv
module cbc_data_buf #(
    parameter int BUF_BYTES = 128,
    localparam int BI_W     = $clog2(BUF_BYTES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [11:0] idx,
    input  logic [2:0]  size,
    input  logic [31:0] wdata,
    input  logic [11:0] rd_idx,
    output logic [31:0] rd_word,
    output logic [31:0] hdr_len
);
    logic [7:0] mem_q [BUF_BYTES];
    logic [7:0] mem_d [BUF_BYTES];

    always_comb begin
        for (int j = 0; j < BUF_BYTES; j++) begin
            logic [11:0] lane;
            lane     = 12'(j) - idx;
            mem_d[j] = mem_q[j];
            if (wr && (12'(j) >= idx) && (lane < 12'(size)))
                mem_d[j] = wdata[lane[1:0]*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        for (int j = 0; j < BUF_BYTES; j++) begin
            if (!rst_n) mem_q[j] <= 8'h00;
            else        mem_q[j] <= mem_d[j];
        end
    end

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            logic [11:0] bi;
            bi = rd_idx + 12'(k);
            rd_word[k*8 +: 8] = (int'(bi) < BUF_BYTES) ? mem_q[bi[BI_W-1:0]] : 8'h00;
        end
        hdr_len = {mem_q[2], mem_q[3], mem_q[4], mem_q[5]};
    end

    // R3: header bytes change only on a buffer write
    p_buf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(hdr_len));
endmodule

// File: rtl/cbc_ctrl_core.sv
module cbc_ctrl_core
    import cbc_pkg::*;
#(
    parameter int LOC_W     = 4,
    parameter int BUF_BYTES = 128,
    localparam int LEN_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_hit_t         hit,
    input  logic [31:0]      val,
    input  logic [LOC_W-1:0] loc,
    input  logic [31:0]      hdr_len,
    input  logic             done_valid,
    input  logic             done_err,
    output ctrl_state_t      st,
    output logic             req_valid,
    output logic [LEN_W-1:0] req_len,
    output logic             cancel_pulse
);
    typedef struct packed {
        ctrl_state_t      st;
        logic             req;
        logic [LEN_W-1:0] len;
        logic             cxl;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d     = core_q;
        core_d.req = 1'b0;
        core_d.cxl = 1'b0;

        if (hit.ctrl_req) begin
            if (val == CODE_READY)     core_d.st.idle = 1'b0;
            else if (val == CODE_IDLE) core_d.st.idle = 1'b1;
        end

        if (hit.loc_ctrl) begin
            if (val == CODE_LOC_REQ) begin
                core_d.st.granted  = 1'b1;
                core_d.st.seized   = 1'b0;
                core_d.st.assigned = 1'b1;
            end else if (val == CODE_LOC_FREE) begin
                core_d.st.granted  = 1'b0;
                core_d.st.assigned = 1'b0;
            end
        end

        if (hit.cancel && (val == CODE_CANCEL) && core_q.st.start)
            core_d.cxl = 1'b1;

        if (done_valid) begin
            core_d.st.start = 1'b0;
            if (done_err) core_d.st.fatal = 1'b1;
        end

        if (hit.start && (val == CODE_START) && !core_q.st.start &&
            core_q.st.assigned && (32'(core_q.st.act_loc) == 32'(loc))) begin
            core_d.st.start = 1'b1;
            core_d.req      = 1'b1;
            core_d.len      = (hdr_len > 32'(BUF_BYTES)) ? LEN_W'(BUF_BYTES)
                                                         : hdr_len[LEN_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q     <= '0;
            core_q.st  <= ST_RST;
        end else begin
            core_q     <= core_d;
        end
    end

    assign st           = core_q.st;
    assign req_valid    = core_q.req;
    assign req_len      = core_q.len;
    assign cancel_pulse = core_q.cxl;

    // R6: a request only accompanies an in-flight command
    p_req_in_flight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> st.start);
    // R6: request lasts one cycle
    p_req_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);
    // R7: length never exceeds the buffer
    p_len_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (32'(req_len) <= 32'(BUF_BYTES)));
    // R8: cancel follows an in-flight cycle only
    p_cancel_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_pulse |-> $past(st.start));
    // R5: granted and assigned move together
    p_grant_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st.granted == st.assigned);
    // R9: completion ends the command; fatal is sticky
    p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && st.start) |=> !st.start);
    p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st.fatal |=> st.fatal);
    // R4: ready code clears idle
    p_ready_clears_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit.ctrl_req && val == CODE_READY) |=> !st.idle);
endmodule

// File: rtl/cmd_buf_ctrl.sv
module cmd_buf_ctrl
    import cbc_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          BUF_BYTES = 128,
    parameter logic [63:0] BASE_ADDR = 64'h0000_0000_FED4_0000,
    parameter logic [31:0] DEV_ID2   = 32'h0000_0000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [31:0]                      bus_wdata,
    input  logic [2:0]                       bus_size,
    input  logic [11:0]                      rd_off,
    output logic [31:0]                      rd_data,
    output logic                             req_valid,
    output logic [$clog2(BUF_BYTES+1)-1:0]   req_len,
    output logic                             cancel_pulse,
    input  logic                             done_valid,
    input  logic                             done_err
);
    localparam int          LOC_W    = ADDR_W - 12;
    localparam logic [63:0] BUF_ADDR = BASE_ADDR + 64'(OFF_BUF);

    logic [LOC_W-1:0] loc;
    logic [31:0]      val;
    reg_hit_t         hit;
    logic             buf_wr;
    logic [11:0]      buf_idx;
    logic [31:0]      buf_word;
    logic [31:0]      hdr_len;
    ctrl_state_t      st;
    logic [11:0]      word_off;
    logic [11:0]      rd_idx;
    logic             rd_in_buf;

    cbc_wr_decode #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_dec (
        .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .size(bus_size),
        .loc(loc), .val(val), .hit(hit), .buf_wr(buf_wr), .buf_idx(buf_idx));

    cbc_data_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr(buf_wr), .idx(buf_idx), .size(bus_size),
        .wdata(bus_wdata), .rd_idx(rd_idx), .rd_word(buf_word), .hdr_len(hdr_len));

    cbc_ctrl_core #(.LOC_W(LOC_W), .BUF_BYTES(BUF_BYTES)) u_core (
        .clk(clk), .rst_n(rst_n), .hit(hit), .val(val), .loc(loc),
        .hdr_len(hdr_len), .done_valid(done_valid), .done_err(done_err),
        .st(st), .req_valid(req_valid), .req_len(req_len),
        .cancel_pulse(cancel_pulse));

    always_comb begin
        word_off  = rd_off & 12'hFFC;
        rd_idx    = word_off - OFF_BUF;
        rd_in_buf = (int'(word_off) >= int'(OFF_BUF)) &&
                    (int'(word_off) < int'(OFF_BUF) + BUF_BYTES);
        rd_data   = 32'h0;
        if (rd_in_buf) begin
            rd_data = buf_word;
        end else begin
            case (word_off)
                OFF_LOC_STATE: rd_data = {24'd0, st.reg_valid, 2'b00, st.act_loc,
                                          st.assigned, st.established};
                OFF_LOC_STS:   rd_data = {30'd0, st.seized, st.granted};
                OFF_IF_ID:     rd_data = cap_word();
                OFF_IF_ID2:    rd_data = DEV_ID2;
                OFF_CTRL_STS:  rd_data = {30'd0, st.idle, st.fatal};
                OFF_START:     rd_data = {31'd0, st.start};
                OFF_CMD_SIZE,
                OFF_RSP_SIZE:  rd_data = 32'(BUF_BYTES);
                OFF_CMD_LO,
                OFF_RSP_LO:    rd_data = BUF_ADDR[31:0];
                OFF_CMD_HI,
                OFF_RSP_HI:    rd_data = BUF_ADDR[63:32];
                default:       rd_data = 32'h0;
            endcase
        end
    end

    // R1: register-valid stays set after reset
    p_reg_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st.reg_valid && st.established);
endmodule

// File: tb/tb_cmd_buf_ctrl.sv
`timescale 1ns/1ps
module tb_cmd_buf_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [2:0]  bus_size;
    logic [11:0] rd_off;
    logic [31:0] rd_data;
    logic        req_valid;
    logic [7:0]  req_len;
    logic        cancel_pulse;
    logic        done_valid;
    logic        done_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    cmd_buf_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_size(bus_size), .rd_off(rd_off),
        .rd_data(rd_data), .req_valid(req_valid), .req_len(req_len),
        .cancel_pulse(cancel_pulse), .done_valid(done_valid), .done_err(done_err));

    typedef struct packed {
        logic [15:0] wa;
        logic [31:0] wd;
        logic [2:0]  ws;
        logic [11:0] ra;
        logic [31:0] ex;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{16'h0080, 32'h04030201, 3'd4, 12'h080, 32'h04030201, 8'd3},  // R3 word
        '{16'h0085, 32'h000000AB, 3'd1, 12'h084, 32'h0000AB00, 8'd3},  // R3 byte lane
        '{16'h0086, 32'h0000BEEF, 3'd2, 12'h084, 32'hBEEFAB00, 8'd3},  // R3 half
        '{16'h0088, 32'hFFFFFFFF, 3'd0, 12'h088, 32'h00000000, 8'd3},  // R3 size 0
        '{16'h0088, 32'hFFFFFFFF, 3'd5, 12'h088, 32'h00000000, 8'd3},  // R3 size 5
        '{16'h00FE, 32'h11223344, 3'd4, 12'h0FC, 32'h33440000, 8'd3},  // R3 end drop
        '{16'h0040, 32'h00000001, 3'd4, 12'h044, 32'h00000000, 8'd4},  // R4 ready
        '{16'h0040, 32'h00000003, 3'd4, 12'h044, 32'h00000000, 8'd4},  // R4 other
        '{16'h0040, 32'h00000002, 3'd4, 12'h044, 32'h00000002, 8'd4},  // R4 idle
        '{16'h0040, 32'h00000101, 3'd1, 12'h044, 32'h00000000, 8'd10}, // R10 masked
        '{16'h0040, 32'h00000102, 3'd4, 12'h044, 32'h00000000, 8'd10}, // R10 full
        '{16'h0008, 32'h00000001, 3'd4, 12'h00C, 32'h00000001, 8'd5},  // R5 request
        '{16'h0FFC, 32'h00000000, 3'd0, 12'h000, 32'h00000083, 8'd5},  // R5 assigned
        '{16'h0008, 32'h00000008, 3'd4, 12'h000, 32'h00000083, 8'd5},  // R5 ignored
        '{16'h0008, 32'h00000002, 3'd4, 12'h00C, 32'h00000000, 8'd5},  // R5 release
        '{16'h0FFC, 32'h00000000, 3'd0, 12'h000, 32'h00000081, 8'd5},  // R5 released
        '{16'h0FFC, 32'h00000000, 3'd0, 12'h030, 32'h00025A11, 8'd1},  // R1 cap
        '{16'h0FFC, 32'h00000000, 3'd0, 12'h058, 32'h00000080, 8'd2},  // R2
        '{16'h0FFC, 32'h00000000, 3'd0, 12'h064, 32'h00000080, 8'd2},  // R2
        '{16'h0FFC, 32'h00000000, 3'd0, 12'h05C, 32'hFED40080, 8'd2},  // R2
        '{16'h0FFC, 32'h00000000, 3'd0, 12'h068, 32'hFED40080, 8'd2},  // R2
        '{16'h0FFC, 32'h00000000, 3'd0, 12'h06C, 32'h00000000, 8'd2},  // R2
        '{16'h0FFC, 32'h00000000, 3'd0, 12'h083, 32'h04030201, 8'd11}, // R11 unaligned
        '{16'h0FFC, 32'h00000000, 3'd0, 12'h100, 32'h00000000, 8'd11}, // R11 past buf
        '{16'h0FFC, 32'h00000000, 3'd0, 12'h050, 32'h00000000, 8'd11}, // R11 hole
        '{16'h0048, 32'h00000001, 3'd4, 12'h048, 32'h00000000, 8'd8}   // R8 idle cancel
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d, input logic [2:0] s);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = s;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        rd_off = a;
        #1;
        chk(rd_data, exp, tag);
    endtask

    task automatic complete(input logic err);
        @(negedge clk);
        done_valid = 1'b1; done_err = err;
        @(negedge clk);
        done_valid = 1'b0; done_err = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bus_wr = 0; bus_addr = 0; bus_wdata = 0; bus_size = 0; rd_off = 0;
        done_valid = 0; done_err = 0;
        do_reset();

        // R1 reset state
        read_chk(12'h000, 32'h81, "R1 loc state");
        read_chk(12'h044, 32'h2,  "R1 ctrl sts");
        read_chk(12'h00C, 32'h0,  "R1 loc sts");
        read_chk(12'h04C, 32'h0,  "R1 start");
        chk({31'd0, req_valid}, 32'd0, "R1 req idle");

        for (int i = 0; i < NV; i++) begin
            bus_write(VECS[i].wa, VECS[i].wd, VECS[i].ws);
            chk({30'd0, req_valid, cancel_pulse}, 32'd0, "R6/R8 no pulse");
            read_chk(VECS[i].ra, VECS[i].ex, $sformatf("R%0d vec %0d", VECS[i].rq, i));
        end

        // R6 start without an assigned locality
        bus_write(16'h004C, 32'h1, 3'd4);
        chk({31'd0, req_valid}, 32'd0, "R6 unassigned");
        read_chk(12'h04C, 32'h0, "R6 unassigned start bit");
        bus_write(16'h0008, 32'h1, 3'd4);
        // R6 foreign locality
        bus_write(16'h104C, 32'h1, 3'd4);
        chk({31'd0, req_valid}, 32'd0, "R6 foreign locality");
        read_chk(12'h04C, 32'h0, "R6 foreign start bit");
        // R7 header length 10
        bus_write(16'h0080, 32'h00008001, 3'd4);
        bus_write(16'h0084, 32'h00000A00, 3'd4);
        bus_write(16'h004C, 32'h1, 3'd4);
        chk({31'd0, req_valid}, 32'd1, "R6 accepted");
        chk({24'd0, req_len}, 32'd10, "R7 length");
        read_chk(12'h04C, 32'h1, "R6 start bit");
        @(negedge clk);
        chk({31'd0, req_valid}, 32'd0, "R6 single cycle");
        bus_write(16'h004C, 32'h1, 3'd4);
        chk({31'd0, req_valid}, 32'd0, "R6 in flight");
        // R8 cancel
        bus_write(16'h0048, 32'h2, 3'd4);
        chk({31'd0, cancel_pulse}, 32'd0, "R8 wrong code");
        bus_write(16'h0048, 32'h1, 3'd4);
        chk({31'd0, cancel_pulse}, 32'd1, "R8 cancel");
        @(negedge clk);
        chk({31'd0, cancel_pulse}, 32'd0, "R8 cancel one cycle");
        // R9 clean completion
        complete(1'b0);
        read_chk(12'h04C, 32'h0, "R9 start cleared");
        read_chk(12'h044, 32'h0, "R9 no fatal");
        bus_write(16'h0048, 32'h1, 3'd4);
        chk({31'd0, cancel_pulse}, 32'd0, "R8 after completion");
        // R7 cap
        bus_write(16'h0084, 32'h0000FFFF, 3'd4);
        bus_write(16'h004C, 32'h1, 3'd4);
        chk({31'd0, req_valid}, 32'd1, "R6 second start");
        chk({24'd0, req_len}, 32'd128, "R7 capped");
        complete(1'b1);
        read_chk(12'h044, 32'h1, "R9 fatal");
        read_chk(12'h04C, 32'h0, "R9 start cleared err");
        bus_write(16'h0084, 32'h00007F00, 3'd4);
        bus_write(16'h004C, 32'h1, 3'd4);
        chk({24'd0, req_len}, 32'd127, "R7 below cap");
        complete(1'b0);
        read_chk(12'h044, 32'h1, "R9 fatal sticky");

        // R1 reset mid-run
        do_reset();
        read_chk(12'h000, 32'h81, "R1 re-reset loc");
        read_chk(12'h044, 32'h2,  "R1 re-reset sts");
        read_chk(12'h080, 32'h0,  "R1 buffer cleared");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule